// File: doc/BRIEF.md
# Visibility Record SPEAD Packetiser

This block turns a stream of per-baseline visibility records into SPEAD packets. A record is a fixed block of `REC_BYTES` bytes (35 by default) that holds one baseline's correlated data for one fine channel. Records arrive one at a time on a valid/ready input. The block groups them into heaps, and each heap is a two-dimensional array of `NUM_BL` baselines by `NUM_CH` fine channels (36 by 20 by default). The records must arrive channel-major: every baseline of channel 0 first, in ascending baseline order, then every baseline of channel 1, and so on to the last channel.

Each channel of a heap goes out as one packet. A packet is a SPEAD header, then four immediate item pointers, then that channel's records. The heap belongs to one of `NUM_STREAMS` logical output streams (744 by default). The block takes the stream index from the first record of the heap and keeps a separate heap counter for every stream. Output is byte-wide, with valid, ready, start-of-packet and end-of-packet signals, plus the stream index of the packet being sent. UDP, IP and Ethernet framing happen further down the chain.

Top module: `vis_spead_packetiser`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high. Every stream's heap counter starts at 0.
- R2: A packet is exactly 40 + `NUM_BL`*`REC_BYTES` bytes long. It begins with the eight header bytes 0x53, 0x04, 0x02, 0x06, 0x00, 0x00, 0x00, 0x04. `out_sop` is high only on the first byte and `out_eop` is high only on the last byte.
- R3: Header bytes 8 to 39 are four 8-byte item pointers, each sent most significant byte first. Each pointer is bit 63 set, a 15-bit item id in bits 62:48, and a 48-bit value in bits 47:0. The ids, in order, are 1 (heap counter), 2 (heap size = `NUM_BL`*`NUM_CH`*`REC_BYTES`), 3 (heap offset) and 4 (payload length = `NUM_BL`*`REC_BYTES`).
- R4: Within a heap, packet k carries channel k. Its heap offset is k times the payload length, so the offset grows by one payload per packet.
- R5: A record's payload bytes are sent most significant byte of `in_record` first. Records keep the order in which they were accepted.
- R6: The stream index is sampled from `in_stream` on the first record of a heap (baseline 0, channel 0). Every packet of that heap shows it on `out_stream`. `in_stream` on the other records of the heap is ignored.
- R7: Each stream keeps its own heap counter. A stream's counter increases by one after each heap completed on that stream, and heaps on other streams leave it unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop`, `out_eop` and `out_stream` hold their values. No byte is dropped or repeated.
- R9: A record is accepted when `in_valid` and `in_ready` are both high. `in_ready` stays low until every output byte that the record produces has been sent.
- R10: A heap counter wraps modulo 2^`HCNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Record present |
| in_ready | output | 1 | Block can accept a record |
| in_record | input | REC_BYTES*8 | Visibility record, first byte in the top bits |
| in_stream | input | STREAM_W | Logical stream index, sampled at the start of a heap |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Packet byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_stream | output | STREAM_W | Stream index of the current packet |

## Verification
The hardest state to reach from the ports is a heap counter wrapping on one stream while other streams keep counting independently. The bench sets `HCNT_W` to 2 and sends five heaps back to back on one stream, so that counter wraps to 0. It then interleaves heaps on other streams. Heaps whose later records carry a wrong stream index check that only the first record's index counts. Backpressure runs in three regimes (none, random, and long stalls), so that stalls land on header bytes, record bytes and packet boundaries.

// File: rtl/vis_spead_pkg.sv
package vis_spead_pkg;

   localparam int HDR_WORDS = 5;
   localparam int HDR_BYTES = HDR_WORDS * 8;

   // magic, version, pointer width, address width, reserved, item count
   localparam logic [63:0] SPEAD_BASE_HDR = 64'h5304_0206_0000_0004;

   localparam logic [14:0] ID_HEAP_CNT  = 15'd1;
   localparam logic [14:0] ID_HEAP_SIZE = 15'd2;
   localparam logic [14:0] ID_HEAP_OFF  = 15'd3;
   localparam logic [14:0] ID_PAY_LEN   = 15'd4;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_HDR  = 2'd1,
      ST_REC  = 2'd2
   } fmt_state_t;

   function automatic logic [63:0] imm_item(input logic [14:0] id, input logic [47:0] val);
      return {1'b1, id, val};
   endfunction

endpackage

// File: rtl/vis_heap_ctr.sv
module vis_heap_ctr #(
   parameter int NUM_STREAMS = 744,
   parameter int HCNT_W      = 16,
   localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HCNT_W-1:0] rd_cnt,
   input  logic              inc_en,
   input  logic [IDX_W-1:0]  inc_idx
);

   logic [HCNT_W-1:0] cnt_q [NUM_STREAMS];

   always_comb begin
      rd_cnt = '0;
      if (int'(rd_idx) < NUM_STREAMS) rd_cnt = cnt_q[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_STREAMS; i++) cnt_q[i] <= '0;
      end else if (inc_en && (int'(inc_idx) < NUM_STREAMS)) begin
         cnt_q[inc_idx] <= cnt_q[inc_idx] + 1'b1;
      end
   end

   // R7 / R10: a completed heap advances its own stream counter by one, modulo width
   p_ctr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inc_en |=> cnt_q[$past(inc_idx)] == HCNT_W'($past(cnt_q[inc_idx]) + 1'b1));

endmodule

// File: rtl/vis_hdr_rom.sv
module vis_hdr_rom
   import vis_spead_pkg::*;
#(
   parameter int NUM_BL    = 36,
   parameter int NUM_CH    = 20,
   parameter int REC_BYTES = 35,
   parameter int HCNT_W    = 16
) (
   input  logic [5:0]        byte_idx,
   input  logic [HCNT_W-1:0] heap_cnt,
   input  logic [47:0]       heap_off,
   output logic [7:0]        hdr_byte
);

   localparam logic [47:0] PAY_BYTES  = 48'(NUM_BL * REC_BYTES);
   localparam logic [47:0] HEAP_BYTES = 48'(NUM_BL * NUM_CH * REC_BYTES);

   logic [63:0] words [8];
   logic [14:0] ids   [4];
   logic [47:0] vals  [4];

   always_comb begin
      ids[0] = ID_HEAP_CNT;  vals[0] = 48'(heap_cnt);
      ids[1] = ID_HEAP_SIZE; vals[1] = HEAP_BYTES;
      ids[2] = ID_HEAP_OFF;  vals[2] = heap_off;
      ids[3] = ID_PAY_LEN;   vals[3] = PAY_BYTES;
   end

   assign words[0] = SPEAD_BASE_HDR;
   for (genvar gi = 0; gi < 4; gi++) begin : g_item
      assign words[gi+1] = imm_item(ids[gi], vals[gi]);
   end
   for (genvar gz = HDR_WORDS; gz < 8; gz++) begin : g_pad
      assign words[gz] = '0;
   end

   logic [63:0] sel_word;
   always_comb begin
      sel_word = words[byte_idx[5:3]];
      hdr_byte = sel_word[63 - 8*int'(byte_idx[2:0]) -: 8];
   end

endmodule

// File: rtl/vis_rec_serial.sv
module vis_rec_serial #(
   parameter int REC_BYTES = 35
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [REC_BYTES*8-1:0] load_rec,
   input  logic                   advance,
   output logic [7:0]             cur_byte
);

   localparam int REC_W = REC_BYTES * 8;

   logic [REC_W-1:0] rec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) rec_q <= '0;
      else if (load) rec_q <= load_rec;
      else if (advance) rec_q <= rec_q << 8;
   end

   assign cur_byte = rec_q[REC_W-1 -: 8];

endmodule

// File: rtl/vis_spead_packetiser.sv
module vis_spead_packetiser
   import vis_spead_pkg::*;
#(
   parameter int NUM_BL      = 36,
   parameter int NUM_CH      = 20,
   parameter int REC_BYTES   = 35,
   parameter int NUM_STREAMS = 744,
   parameter int HCNT_W      = 16,
   localparam int STREAM_W   = $clog2(NUM_STREAMS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [REC_BYTES*8-1:0] in_record,
   input  logic [STREAM_W-1:0]    in_stream,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [7:0]             out_data,
   output logic                   out_sop,
   output logic                   out_eop,
   output logic [STREAM_W-1:0]    out_stream
);

   localparam int BL_W      = $clog2(NUM_BL);
   localparam int CH_W      = $clog2(NUM_CH);
   localparam int CNT_MAX   = (HDR_BYTES > REC_BYTES) ? HDR_BYTES : REC_BYTES;
   localparam int CNT_W     = $clog2(CNT_MAX + 1);
   localparam int PKT_BYTES = HDR_BYTES + NUM_BL * REC_BYTES;
   localparam int PKT_W     = $clog2(PKT_BYTES + 1);
   localparam logic [47:0] PAY_BYTES = 48'(NUM_BL * REC_BYTES);

   // elaboration-time parameter checks
   if (NUM_BL < 2)          begin : g_bad_bl   $error("NUM_BL must be at least 2");        end
   if (NUM_CH < 2)          begin : g_bad_ch   $error("NUM_CH must be at least 2");        end
   if (REC_BYTES < 1)       begin : g_bad_rec  $error("REC_BYTES must be positive");       end
   if (NUM_STREAMS < 2)     begin : g_bad_str  $error("NUM_STREAMS must be at least 2");   end
   if (HCNT_W < 1 || HCNT_W > 48) begin : g_bad_hc $error("HCNT_W must lie in 1..48");    end
   if (CNT_W > 6 && REC_BYTES < 64) begin : g_bad_cnt $error("byte counter sizing");       end

   fmt_state_t             state_q;
   logic [CNT_W-1:0]       byte_q;
   logic [BL_W-1:0]        bl_q;
   logic [CH_W-1:0]        ch_q;
   logic [STREAM_W-1:0]    stream_q;
   logic [HCNT_W-1:0]      hcnt_q;
   logic [47:0]            off_q;

   logic                   accept, fire, rec_last, hdr_last, bl_last, ch_last, heap_done;
   logic [HCNT_W-1:0]      ctr_rd;
   logic [7:0]             hdr_byte, rec_byte;

   assign accept    = in_valid && in_ready;
   assign fire      = out_valid && out_ready;
   assign hdr_last  = (byte_q == CNT_W'(HDR_BYTES - 1));
   assign rec_last  = (byte_q == CNT_W'(REC_BYTES - 1));
   assign bl_last   = (bl_q == BL_W'(NUM_BL - 1));
   assign ch_last   = (ch_q == CH_W'(NUM_CH - 1));
   assign heap_done = fire && (state_q == ST_REC) && rec_last && bl_last && ch_last;

   vis_heap_ctr #(
      .NUM_STREAMS (NUM_STREAMS),
      .HCNT_W      (HCNT_W)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (in_stream),
      .rd_cnt  (ctr_rd),
      .inc_en  (heap_done),
      .inc_idx (stream_q)
   );

   vis_hdr_rom #(
      .NUM_BL    (NUM_BL),
      .NUM_CH    (NUM_CH),
      .REC_BYTES (REC_BYTES),
      .HCNT_W    (HCNT_W)
   ) u_hdr (
      .byte_idx (6'(byte_q)),
      .heap_cnt (hcnt_q),
      .heap_off (off_q),
      .hdr_byte (hdr_byte)
   );

   vis_rec_serial #(
      .REC_BYTES (REC_BYTES)
   ) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_rec (in_record),
      .advance  (fire && (state_q == ST_REC)),
      .cur_byte (rec_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_WAIT;
         byte_q   <= '0;
         bl_q     <= '0;
         ch_q     <= '0;
         stream_q <= '0;
         hcnt_q   <= '0;
         off_q    <= '0;
      end else begin
         unique case (state_q)
            ST_WAIT: begin
               if (accept) begin
                  byte_q <= '0;
                  if (bl_q == '0) begin
                     state_q <= ST_HDR;
                     if (ch_q == '0) begin
                        stream_q <= in_stream;
                        hcnt_q   <= ctr_rd;
                        off_q    <= '0;
                     end
                  end else begin
                     state_q <= ST_REC;
                  end
               end
            end
            ST_HDR: begin
               if (fire) begin
                  if (hdr_last) begin
                     state_q <= ST_REC;
                     byte_q  <= '0;
                  end else begin
                     byte_q <= byte_q + 1'b1;
                  end
               end
            end
            ST_REC: begin
               if (fire) begin
                  if (rec_last) begin
                     state_q <= ST_WAIT;
                     byte_q  <= '0;
                     if (bl_last) begin
                        bl_q  <= '0;
                        off_q <= off_q + PAY_BYTES;
                        ch_q  <= ch_last ? '0 : ch_q + 1'b1;
                     end else begin
                        bl_q <= bl_q + 1'b1;
                     end
                  end else begin
                     byte_q <= byte_q + 1'b1;
                  end
               end
            end
            default: state_q <= ST_WAIT;
         endcase
      end
   end

   assign in_ready   = (state_q == ST_WAIT);
   assign out_valid  = (state_q != ST_WAIT);
   assign out_data   = (state_q == ST_HDR) ? hdr_byte : rec_byte;
   assign out_sop    = (state_q == ST_HDR) && (byte_q == '0);
   assign out_eop    = (state_q == ST_REC) && rec_last && bl_last;
   assign out_stream = stream_q;

   // packet length tracker for the length assertion
   logic [PKT_W-1:0] pkt_cnt_q;
   always_ff @(posedge clk) begin
      if (!rst_n) pkt_cnt_q <= '0;
      else if (fire) pkt_cnt_q <= out_eop ? '0 : pkt_cnt_q + 1'b1;
   end

   // R8: stalled output holds every field
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
                                  && $stable(out_eop) && $stable(out_stream));

   // R2: first byte of every packet is the magic value
   p_sop_magic_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_valid && out_data == 8'h53);

   // R2: end of packet lands exactly on the last byte
   p_pkt_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_eop |-> pkt_cnt_q == PKT_W'(PKT_BYTES - 1));

   // R9: one record in flight at a time
   p_one_rec_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> !in_ready && out_valid);

   // R6: stream index only changes at a packet start
   p_stream_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_sop |-> $stable(out_stream));

endmodule

// File: tb/vis_spead_packetiser_tb.sv
module vis_spead_packetiser_tb;

   localparam int NB  = 3;
   localparam int NC  = 2;
   localparam int RB  = 5;
   localparam int NS  = 5;
   localparam int HW  = 2;
   localparam int STW = $clog2(NS);
   localparam int EW  = 8 + 2 + STW;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic               rst_n;
   logic               in_valid;
   logic               in_ready;
   logic [RB*8-1:0]    in_record;
   logic [STW-1:0]     in_stream;
   logic               out_valid;
   logic               out_ready;
   logic [7:0]         out_data;
   logic               out_sop;
   logic               out_eop;
   logic [STW-1:0]     out_stream;

   vis_spead_packetiser #(
      .NUM_BL (NB), .NUM_CH (NC), .REC_BYTES (RB), .NUM_STREAMS (NS), .HCNT_W (HW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_record (in_record), .in_stream (in_stream),
      .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
      .out_sop (out_sop), .out_eop (out_eop), .out_stream (out_stream)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int ready_mode = 0;
   int hc_model [NS];
   logic [EW-1:0] exp_q [$];
   string         tag_q [$];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic logic [63:0] ptr(input int id, input longint v);
      return {1'b1, 15'(id), 48'(v)};
   endfunction

   function automatic string hdr_tag(input int k);
      if (k < 8)  return "R2";
      if (k < 16) return "R7";
      if (k < 24) return "R3";
      if (k < 32) return "R4";
      return "R3";
   endfunction

   // builds the expected bytes of one heap, then drives its records
   task automatic run_heap(input int strm, input bit noisy_stream);
      logic [RB*8-1:0] recs [NB*NC];
      logic [63:0] w [5];
      int hc;
      for (int i = 0; i < NB*NC; i++)
         recs[i] = {$urandom, $urandom};
      hc = hc_model[strm];
      for (int ch = 0; ch < NC; ch++) begin
         w[0] = 64'h5304_0206_0000_0004;
         w[1] = ptr(1, hc);
         w[2] = ptr(2, NB*NC*RB);
         w[3] = ptr(3, ch*NB*RB);
         w[4] = ptr(4, NB*RB);
         for (int k = 0; k < 40; k++) begin
            exp_q.push_back({(k == 0), 1'b0, STW'(strm), w[k/8][63-8*(k%8) -: 8]});
            tag_q.push_back(hdr_tag(k));
         end
         for (int b = 0; b < NB; b++) begin
            for (int j = 0; j < RB; j++) begin
               exp_q.push_back({1'b0, (b == NB-1 && j == RB-1), STW'(strm),
                                recs[ch*NB+b][RB*8-1-8*j -: 8]});
               tag_q.push_back("R5");
            end
         end
      end
      hc_model[strm] = (hc + 1) % (1 << HW);
      for (int i = 0; i < NB*NC; i++) begin
         int s;
         bit acc;
         s = (noisy_stream && i != 0) ? ((strm + 1 + i) % NS) : strm;
         @(negedge clk);
         in_valid  = 1'b1;
         in_record = recs[i];
         in_stream = STW'(s);
         forever begin
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
         end
         check(in_ready == 1'b0, "R9", "in_ready after accept", in_ready, 0);
         in_valid = 1'b0;
         repeat ($urandom_range(0, 2)) @(negedge clk);
      end
   endtask

   // output monitor and ready driver
   initial begin : mon
      bit stall_prev;
      logic [EW-1:0] held, act, expv;
      string tag;
      stall_prev = 1'b0;
      held = '0;
      out_ready = 1'b0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         act = {out_sop, out_eop, out_stream, out_data};
         if (stall_prev)
            check(out_valid && act == held, "R8", "held output under stall", act, held);
         case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = ($urandom_range(0, 1) == 1);
            default: out_ready = ($urandom_range(0, 5) == 0);
         endcase
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "unexpected byte", act, 0);
            end else begin
               expv = exp_q.pop_front();
               tag  = tag_q.pop_front();
               if (act[EW-1 -: 2] != expv[EW-1 -: 2]) tag = "R2";
               else if (act[STW+7:8] != expv[STW+7:8]) tag = "R6";
               check(act == expv, tag, "byte/sop/eop/stream", act, expv);
            end
         end
         stall_prev = out_valid && !out_ready;
         held = act;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      for (int i = 0; i < NS; i++) hc_model[i] = 0;
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_record = '0;
      in_stream = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

      // R10 / R7: five heaps on one stream, counter wraps after four
      ready_mode = 0;
      for (int h = 0; h < 5; h++) run_heap(0, 1'b0);
      // R7 / R6: other streams, later records with wrong stream index
      ready_mode = 1;
      run_heap(2, 1'b1);
      run_heap(4, 1'b1);
      run_heap(2, 1'b0);
      run_heap(0, 1'b1);
      // R8: long stalls
      ready_mode = 2;
      run_heap(3, 1'b0);
      run_heap(1, 1'b1);
      // random mix
      for (int h = 0; h < 16; h++) begin
         ready_mode = $urandom_range(0, 2);
         run_heap($urandom_range(0, NS-1), $urandom_range(0, 1) == 1);
      end
      ready_mode = 0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && in_ready == 1'b1, "R9", "idle after drain",
            {out_valid, in_ready}, 2'b01);
      summary();
      $finish;
   end

endmodule